// File: doc/BRIEF.md
# Timestamp and Pulse-Tick Generator

This block keeps one wide free-running timestamp counter that advances on every cycle in which the reference-tick input is high. It produces three coarse timestamps for three consumers: a data-path log, a tag and an address-translation timer. Each coarse timestamp is the counter shifted right by a shift amount programmed for that consumer.

A programmable divider turns the reference ticks into a common timer tick. Three pulse generators count common ticks. Each one emits a single-cycle strobe at a granularity chosen from a fixed menu of periods.

Software configures the block through a write-only register port with three registers:

- Timestamp control (address 0)
- Granularity control (address 1)
- Divider control (address 2)

When the divider runs at the nominal rate, it divides a 19.2 MHz reference by 192 to give a 100 kHz common tick. The granularity menu is expressed in those ticks.

Top module: `tick_timebase`

## Requirements
- R1: Reset clears the timestamp counter, the divider enable and value, all shift, select and granularity fields, and the millisecond counter. All coarse timestamp outputs and all strobes are zero while and after reset, until the first reference tick.
- R2: The TS_W-bit counter increments by exactly one at each clock edge where `ref_tick` is high, and holds its value at every other edge.
- R3: Timestamp control (address 0) holds three shift fields: data-path log in bits [5:0], tag in bits [13:8] and address-translation in bits [21:16]. Each coarse output is the low OUT_W bits of the counter shifted right by its own field.
- R4: Bit 7 of timestamp control selects the source of `ts_log`. A value of 1 gives the shifted counter. A value of 0 gives a millisecond count, which advances once every MS_TICKS common ticks.
- R5: Divider control (address 2) holds the ratio minus one in bits [DIV_W-1:0] and the enable in bit 31. While enabled, a common tick occurs once every (value+1) reference ticks.
- R6: A write to divider control while the divider is enabled updates only the enable bit. The value written is ignored.
- R7: While the divider is disabled, its count is held at zero and no common tick occurs. As a result, no strobe fires and the millisecond count does not advance.
- R8: Granularity control (address 1) holds generator g's 3-bit code in bits [4g+2:4g]. The codes 0,1,2,3,4,5,6 mean 1, 2, 5, 10, 100, 1000 and 10000 common ticks, and code 7 behaves like code 6. A generator strobes for one cycle, on the cycle after the common tick that completes each period.
- R9: Any write to granularity control restarts all three generators from zero and suppresses a strobe at that edge. The first strobe then arrives one full new period later.
- R10: A write to address 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference-clock tick enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| ts_log | output | OUT_W | Data-path log timestamp |
| ts_tag | output | OUT_W | Tag timestamp |
| ts_nat | output | OUT_W | Address-translation timestamp |
| pulse | output | 3 | Strobes of the three pulse generators |

## Verification
The bench builds the block with its default parameters: a 56-bit counter, 32-bit outputs, a 16-bit divider and MS_TICKS of 100. It then programs the divider to ratios of 1 and 4 instead of 192, so that every granularity code up to 10000 common ticks completes within the run. A small shift of 0 on the tag output exposes the raw counter, which makes per-tick counting visible. Driving the reference tick continuously, on alternate cycles, randomly and not at all covers stepping, holding and the divider phase against the restart of the generators.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

  localparam logic [1:0] ADDR_TS   = 2'd0;
  localparam logic [1:0] ADDR_GRAN = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  localparam int unsigned DIV_EN_BIT = 31;
  localparam int unsigned LOG_SEL_BIT = 7;

  // Granularity code to period in common ticks
  function automatic int unsigned gran_ticks(input logic [2:0] code);
    case (code)
      3'd0:    gran_ticks = 1;
      3'd1:    gran_ticks = 2;
      3'd2:    gran_ticks = 5;
      3'd3:    gran_ticks = 10;
      3'd4:    gran_ticks = 100;
      3'd5:    gran_ticks = 1000;
      default: gran_ticks = 10000;
    endcase
  endfunction

endpackage

// File: rtl/tpg_ts_counter.sv
`timescale 1ns/1ps
module tpg_ts_counter #(
  parameter int TS_W    = 56,
  parameter int OUT_W   = 32,
  parameter int SHIFT_W = 6,
  parameter int N_CONS  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ref_tick,
  input  logic [N_CONS-1:0][SHIFT_W-1:0]     shift,
  output logic [TS_W-1:0]                    count,
  output logic [N_CONS-1:0][OUT_W-1:0]       coarse
);

  logic [TS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ref_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  for (genvar i = 0; i < N_CONS; i++) begin : g_cons
    assign coarse[i] = OUT_W'(cnt_q >> shift[i]);
  end

endmodule

// File: rtl/tpg_divider.sv
`timescale 1ns/1ps
module tpg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             com_tick
);

  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             hit;

  assign hit      = (dcnt_q == div_val);
  assign com_tick = en & ref_tick & hit;

  always_comb begin
    dcnt_d = dcnt_q;
    if (!en)           dcnt_d = '0;
    else if (ref_tick) dcnt_d = hit ? '0 : dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_d;
  end

endmodule

// File: rtl/tpg_pulse.sv
`timescale 1ns/1ps
module tpg_pulse #(
  parameter int GRAN_W = 3,
  parameter int PCNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              com_tick,
  input  logic              restart,
  input  logic [GRAN_W-1:0] gran,
  output logic              pulse
);

  logic [PCNT_W-1:0] cnt_q, cnt_d;
  logic [PCNT_W-1:0] last_c;
  logic              pulse_d, pulse_q;
  logic              wrap;

  assign last_c = PCNT_W'(tpg_pkg::gran_ticks(3'(gran)) - 1);
  assign wrap   = com_tick & (cnt_q == last_c);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (com_tick) begin
      cnt_d   = wrap ? '0 : cnt_q + 1'b1;
      pulse_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/tick_timebase.sv
`timescale 1ns/1ps
module tick_timebase #(
  parameter int TS_W     = 56,
  parameter int OUT_W    = 32,
  parameter int SHIFT_W  = 6,
  parameter int DIV_W    = 16,
  parameter int GRAN_W   = 3,
  parameter int PCNT_W   = 14,
  parameter int MS_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [OUT_W-1:0] ts_log,
  output logic [OUT_W-1:0] ts_tag,
  output logic [OUT_W-1:0] ts_nat,
  output logic [2:0]       pulse
);

  import tpg_pkg::*;

  localparam int N_CONS = 3;
  localparam int N_GEN  = 3;
  localparam int MS_W   = $clog2(MS_TICKS + 1);

  logic [N_CONS-1:0][SHIFT_W-1:0] shift_q, shift_d;
  logic                           log_sel_q, log_sel_d;
  logic [N_GEN-1:0][GRAN_W-1:0]   gran_q, gran_d;
  logic [DIV_W-1:0]               div_val_q, div_val_d;
  logic                           div_en_q, div_en_d;
  logic [MS_W-1:0]                ms_sub_q, ms_sub_d;
  logic [OUT_W-1:0]               ms_cnt_q, ms_cnt_d;

  logic                           wr_ts, wr_gran, wr_div;
  logic                           com_tick;
  logic [TS_W-1:0]                ts_count;
  logic [N_CONS-1:0][OUT_W-1:0]   coarse;
  logic                           unused_wdata;

  assign wr_ts   = cfg_we && (cfg_addr == ADDR_TS);
  assign wr_gran = cfg_we && (cfg_addr == ADDR_GRAN);
  assign wr_div  = cfg_we && (cfg_addr == ADDR_DIV);
  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    shift_d   = shift_q;
    log_sel_d = log_sel_q;
    gran_d    = gran_q;
    div_val_d = div_val_q;
    div_en_d  = div_en_q;
    ms_sub_d  = ms_sub_q;
    ms_cnt_d  = ms_cnt_q;

    if (wr_ts) begin
      for (int i = 0; i < N_CONS; i++) shift_d[i] = cfg_wdata[8*i +: SHIFT_W];
      log_sel_d = cfg_wdata[LOG_SEL_BIT];
    end

    if (wr_gran) begin
      for (int g = 0; g < N_GEN; g++) gran_d[g] = cfg_wdata[4*g +: GRAN_W];
    end

    if (wr_div) begin
      div_en_d = cfg_wdata[DIV_EN_BIT];
      if (!div_en_q) div_val_d = cfg_wdata[DIV_W-1:0];
    end

    if (com_tick) begin
      if (ms_sub_q == MS_W'(MS_TICKS - 1)) begin
        ms_sub_d = '0;
        ms_cnt_d = ms_cnt_q + 1'b1;
      end else begin
        ms_sub_d = ms_sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      log_sel_q <= 1'b0;
      gran_q    <= '0;
      div_val_q <= '0;
      div_en_q  <= 1'b0;
      ms_sub_q  <= '0;
      ms_cnt_q  <= '0;
    end else begin
      shift_q   <= shift_d;
      log_sel_q <= log_sel_d;
      gran_q    <= gran_d;
      div_val_q <= div_val_d;
      div_en_q  <= div_en_d;
      ms_sub_q  <= ms_sub_d;
      ms_cnt_q  <= ms_cnt_d;
    end
  end

  tpg_ts_counter #(
    .TS_W(TS_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W), .N_CONS(N_CONS)
  ) u_ts (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .shift(shift_q), .count(ts_count), .coarse(coarse)
  );

  tpg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .en(div_en_q), .div_val(div_val_q), .com_tick(com_tick)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    tpg_pulse #(.GRAN_W(GRAN_W), .PCNT_W(PCNT_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .com_tick(com_tick),
      .restart(wr_gran), .gran(gran_q[g]), .pulse(pulse[g])
    );
  end

  assign ts_log = log_sel_q ? coarse[0] : ms_cnt_q;
  assign ts_tag = coarse[1];
  assign ts_nat = coarse[2];

endmodule

// File: rtl/tick_timebase_chk.sv
`timescale 1ns/1ps
module tick_timebase_chk #(
  parameter int TS_W  = 56,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [TS_W-1:0]  ts_count,
  input logic             div_en,
  input logic [DIV_W-1:0] div_val,
  input logic             com_tick,
  input logic [2:0]       pulse
);

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> (ts_count == $past(ts_count) + 1'b1));

  // R2
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(ts_count));

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && $past(div_en)) |-> $stable(div_val));

  // R7
  no_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |-> !com_tick);

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> $past(com_tick));

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd1) |=> (pulse == 3'b000));

endmodule

bind tick_timebase tick_timebase_chk #(.TS_W(TS_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .ts_count(ts_count), .div_en(div_en_q),
  .div_val(div_val_q), .com_tick(com_tick), .pulse(pulse)
);

// File: tb/tick_timebase_tb_top.sv
`timescale 1ns/1ps
module tick_timebase_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] ts_log, ts_tag, ts_nat;
  logic [2:0]  pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ref_mode = 3;  // 0 always, 1 alternate, 2 random, 3 off

  always #10 clk = ~clk;

  tick_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ts_log(ts_log),
    .ts_tag(ts_tag), .ts_nat(ts_nat), .pulse(pulse)
  );

  // reference tick pattern
  bit alt = 1'b0;
  always @(negedge clk) begin
    alt = ~alt;
    case (ref_mode)
      0: ref_tick <= 1'b1;
      1: ref_tick <= alt;
      2: ref_tick <= 1'($urandom_range(0, 1));
      default: ref_tick <= 1'b0;
    endcase
  end

  // behavioural reference model
  longint unsigned m_ts = 0;
  longint unsigned mask56 = (64'd1 << 56) - 1;
  int m_sh[3] = '{0, 0, 0};
  bit m_sel = 0;
  int m_gran[3] = '{0, 0, 0};
  int m_pc[3] = '{0, 0, 0};
  bit [2:0] m_pulse = 0;
  int m_dval = 0;
  bit m_den = 0;
  int m_dcnt = 0;
  int m_msub = 0;
  int unsigned m_ms = 0;

  function automatic int per(int code);
    case (code)
      0: return 1; 1: return 2; 2: return 5; 3: return 10;
      4: return 100; 5: return 1000; default: return 10000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ts = 0; m_sel = 0; m_dval = 0; m_den = 0; m_dcnt = 0;
      m_msub = 0; m_ms = 0; m_pulse = 0;
      for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_gran[i] = 0; m_pc[i] = 0; end
    end else begin
      bit com, rs;
      com = m_den && ref_tick && (m_dcnt == m_dval);
      rs  = cfg_we && cfg_addr == 2'd1;
      for (int i = 0; i < 3; i++) begin
        m_pulse[i] = !rs && com && (m_pc[i] == per(m_gran[i]) - 1);
        if (rs) m_pc[i] = 0;
        else if (com) m_pc[i] = (m_pc[i] == per(m_gran[i]) - 1) ? 0 : m_pc[i] + 1;
      end
      if (!m_den) m_dcnt = 0;
      else if (ref_tick) m_dcnt = (m_dcnt == m_dval) ? 0 : m_dcnt + 1;
      if (com) begin
        if (m_msub == 99) begin m_msub = 0; m_ms++; end
        else m_msub++;
      end
      if (ref_tick) m_ts = (m_ts + 1) & mask56;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin
            m_sh[0] = cfg_wdata[5:0]; m_sh[1] = cfg_wdata[13:8];
            m_sh[2] = cfg_wdata[21:16]; m_sel = cfg_wdata[7];
          end
          2'd1: for (int i = 0; i < 3; i++) m_gran[i] = int'(cfg_wdata[4*i +: 3]);
          2'd2: begin
            if (!m_den) m_dval = int'(cfg_wdata[15:0]);
            m_den = cfg_wdata[31];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      longint unsigned e_log;
      e_log = m_sel ? ((m_ts >> m_sh[0]) & 64'hFFFF_FFFF) : longint'(m_ms);
      check(ts_log == 32'(e_log), "R4 ts_log model", ts_log, e_log);
      check(ts_tag == 32'(m_ts >> m_sh[1]), "R3 ts_tag model", ts_tag, (m_ts >> m_sh[1]) & 64'hFFFF_FFFF);
      check(ts_nat == 32'(m_ts >> m_sh[2]), "R3 ts_nat model", ts_nat, (m_ts >> m_sh[2]) & 64'hFFFF_FFFF);
      check(pulse == m_pulse, "R8 pulse model", pulse, m_pulse);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // gap in cycles between two consecutive strobes of a generator
  task automatic gap(input int g, input int limit, output int n);
    int t = 0;
    n = -1;
    while (!pulse[g] && t < limit) begin @(negedge clk); t++; end
    if (!pulse[g]) return;
    t = 0;
    do begin @(negedge clk); t++; end while (!pulse[g] && t < limit);
    if (pulse[g]) n = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, a, b;
    logic [31:0] s0, s1, s2;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check(ts_log == 0 && ts_tag == 0 && ts_nat == 0 && pulse == 0, "R1 reset outputs", ts_tag, 0);
    rst_n = 1'b1;
    // R3: log shift 2, select 1, tag shift 0, nat shift 4
    wr(2'd0, 32'h0004_0082);
    repeat (3) @(negedge clk);
    check(ts_tag == 0 && pulse == 0, "R1 counter cleared", ts_tag, 0);
    // R2: ten continuous ticks
    ref_mode = 0;
    @(negedge clk);
    a = ts_tag;
    repeat (10) @(negedge clk);
    b = ts_tag;
    check(b - a == 10, "R2 step continuous", b - a, 10);
    check(ts_nat == 32'(b) >> 4, "R3 nat shift", ts_nat, b >> 4);
    // R2: alternate ticks, and hold when off
    ref_mode = 1;
    @(negedge clk);
    a = ts_tag;
    repeat (20) @(negedge clk);
    check(ts_tag - a == 10, "R2 step alternate", ts_tag - a, 10);
    ref_mode = 3;
    @(negedge clk);
    a = ts_tag;
    repeat (8) @(negedge clk);
    check(ts_tag == a, "R2 hold", ts_tag, a);
    check(ts_log == 32'(a) >> 2, "R3 log shift", ts_log, a >> 2);
    // R5/R8: divide by 4, codes 0,1,2
    wr(2'd1, 32'h0000_0210);
    wr(2'd2, 32'h0000_0003);
    wr(2'd2, 32'h8000_0003);
    ref_mode = 0;
    gap(0, 200, n); check(n == 4, "R5 divide by 4", n, 4);
    gap(1, 200, n); check(n == 8, "R8 code 1", n, 8);
    gap(2, 200, n); check(n == 20, "R8 code 2", n, 20);
    // R6: value write while enabled is ignored
    wr(2'd2, 32'h8000_0007);
    gap(0, 200, n); check(n == 4, "R6 value ignored", n, 4);
    // R9: restart, code 3 on gen 1
    wr(2'd1, 32'h0000_0230);
    check(pulse == 0, "R9 quiet after write", pulse, 0);
    n = 0;
    while (!pulse[1] && n < 200) begin @(negedge clk); n++; end
    check(n >= 37 && n <= 40, "R9 first strobe delay", n, 40);
    gap(1, 200, n); check(n == 40, "R9 new period", n, 40);
    // random reference pattern under model comparison
    ref_mode = 2;
    repeat (2000) @(negedge clk);
    ref_mode = 0;
    // R4: millisecond source, divide by 1
    wr(2'd0, 32'h0004_0002);
    wr(2'd2, 32'h0000_0000);
    wr(2'd2, 32'h0000_0000);
    wr(2'd2, 32'h8000_0000);
    s0 = ts_log;
    n = 0;
    while (ts_log == s0 && n < 300) begin @(negedge clk); n++; end
    s0 = ts_log; n = 0;
    while (ts_log == s0 && n < 300) begin @(negedge clk); n++; end
    check(n == 100 && ts_log == s0 + 1, "R4 ms period", n, 100);
    // R8: code 4 and code 6 at divide by 1
    wr(2'd1, 32'h0000_0604);
    gap(0, 300, n); check(n == 100, "R8 code 4", n, 100);
    gap(2, 25000, n); check(n == 10000, "R8 code 6", n, 10000);
    // R7: disabled divider
    wr(2'd2, 32'h0000_0000);
    s0 = ts_log; n = 0;
    repeat (60) begin @(negedge clk); if (pulse != 0) n++; end
    check(n == 0, "R7 no strobe", n, 0);
    check(ts_log == s0, "R7 ms frozen", ts_log, s0);
    // R10: unused address
    ref_mode = 3;
    repeat (2) @(negedge clk);
    s0 = ts_log; s1 = ts_tag; s2 = ts_nat;
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check(ts_log == s0 && ts_tag == s1 && ts_nat == s2, "R10 addr 3 ignored", ts_tag, s1);
    wr(2'd2, 32'h8000_0000);
    ref_mode = 0;
    gap(0, 300, n); check(n == 100, "R10 config kept", n, 100);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule